// File: doc/BRIEF.md
# Flash Command and Lock-Protection Sequencer

This block models the control side of a NOR-style flash device: the command decoder and the write state machine. A host issues bus write cycles, each carrying an address and a data word. The low byte of the data is a command, or the operand of a sequence that is already open. The block runs word programs and lock-bit sets against an internal word array and a store of lock bits. It keeps a status register that records ready, sequence errors, write errors, low-supply and protection violations.

Writes are checked against two levels of protection. Every block has its own lock bit, which stops programs into that block. A single master lock bit stops changes to the block lock bits. A high-voltage-on-reset flag overrides either level. Every rejected operation sets its own combination of status bits and leaves the array and lock store as they were. Reads return either array data or the status register, depending on the current read mode. The `ready` output gives the busy/ready level of the state machine.

The state machine has four states. `ST_IDLE` accepts commands. `ST_PGM_DATA` waits for the program operand. `ST_LOCK_CONF` waits for a lock confirm. `ST_BUSY` counts out the operation time. The transitions are:
- `ST_IDLE` to `ST_PGM_DATA` on a program setup.
- `ST_IDLE` to `ST_LOCK_CONF` on a lock setup.
- `ST_PGM_DATA` to `ST_BUSY` on any write.
- `ST_LOCK_CONF` to `ST_BUSY` on a valid confirm.
- `ST_LOCK_CONF` to `ST_IDLE` on an invalid confirm.
- `ST_BUSY` to `ST_IDLE` when the busy timer expires.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `ready` is 1, reads return array data, every array word is all ones, all block lock bits and the master lock bit are clear, and the status byte reads 80h.
- R2: A program setup (command 40h) followed by a write of address A and data D stores old AND D at A. Bits can only go from 1 to 0. Writing a 1 over a 0 is not an error. A successful program leaves status 80h, and the read mode is status.
- R3: A program, block-lock or master-lock operation made while `vpen_ok` is 0 sets status bit 4 and status bit 3 (status 98h) and changes neither the array nor the lock store. This check takes precedence over the lock checks.
- R4: A program into a block whose lock bit is set, made while `hv_rst` is 0, sets status bits 4 and 1 (status 92h) and leaves the word unchanged. With `hv_rst` at 1, the program goes ahead.
- R5: Lock setup (60h) followed by block confirm (01h) sets the lock bit of the block that holds the confirm address. The block index is the top BLK_W address bits. Other blocks stay writable.
- R6: Lock setup followed by master confirm (F1h, at any address) sets the master lock bit only when `hv_rst` is 1. Otherwise it sets status 92h and the master lock bit stays clear.
- R7: Once the master lock bit is set, a block confirm made while `hv_rst` is 0 sets status 92h and locks nothing. With `hv_rst` at 1, the block confirm succeeds.
- R8: After a lock setup, any confirm byte other than 01h or F1h sets status bits 5 and 4 (status B0h), returns to idle without a busy period, and changes nothing.
- R9: Once the operand or confirm write is accepted, `ready` is 0 and status bit 7 reads 0 for exactly BUSY_CYC cycles. This holds whether the operation succeeds or is rejected.
- R10: Writes made while busy are ignored: they neither start a sequence nor change the read mode.
- R11: Error bits stay set until the clear command (50h), which clears status bits 1, 3, 4 and 5.
- R12: Command 70h selects status reads, FFh selects array reads, and 10h is an alias of 40h. Other command bytes in idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Write strobe, one write per cycle it is high |
| addr | input | ADDR_W | Word address for writes and reads |
| wdata | input | DATA_W | Write data; low byte is the command or confirm code |
| vpen_ok | input | 1 | Program supply above lockout when 1 |
| hv_rst | input | 1 | High voltage present on the reset pin |
| rdata | output | DATA_W | Array word at `addr`, or the zero-extended status byte |
| ready | output | 1 | 1 when the state machine is not busy |

## Verification
Directed programs cover the AND behaviour with fresh words, with 1-over-0 rewrites and with the 10h alias. These show whether the array keeps only 1-to-0 changes and whether such rewrites stay error-free. The lock cases run the same program or confirm under each combination of supply flag, high-voltage flag, block lock and master lock. Because every status value is compared as a whole byte, each protection path can be told apart from the others. Random programs then mix addresses across all blocks with random supply and high-voltage flags. A bench model predicts each status byte and each read-back word. Busy-time writes and invalid confirms test whether the sequencer keeps its state.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PGM_DATA,
        ST_LOCK_CONF,
        ST_BUSY
    } fcs_state_e;

    localparam logic [7:0] CMD_PGM        = 8'h40;
    localparam logic [7:0] CMD_PGM_ALT    = 8'h10;
    localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
    localparam logic [7:0] CMD_CONF_BLOCK = 8'h01;
    localparam logic [7:0] CMD_CONF_MSTR  = 8'hF1;
    localparam logic [7:0] CMD_RD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_RD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_CLR_STATUS = 8'h50;

    localparam int SR_READY = 7;
    localparam int SR_SEQ   = 5;
    localparam int SR_WERR  = 4;
    localparam int SR_VLOW  = 3;
    localparam int SR_PROT  = 1;

    localparam logic [7:0] ERR_MASK = 8'b0011_1010;
endpackage

// File: rtl/fcs_array.sv
`timescale 1ns/1ps
module fcs_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Cells only discharge: a program clears the zero bits of the operand.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (pgm_en) begin
            mem[pgm_addr] <= mem[pgm_addr] & pgm_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fcs_locks.sv
`timescale 1ns/1ps
module fcs_locks #(
    parameter int BLK_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_blk,
    input  logic [BLK_W-1:0]        blk_idx,
    input  logic                    set_master,
    output logic [(1<<BLK_W)-1:0]   blk_lock,
    output logic                    master_lock
);
    localparam int NBLK = 1 << BLK_W;

    generate
        for (genvar b = 0; b < NBLK; b++) begin : g_blk
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    blk_lock[b] <= 1'b0;
                end else if (set_blk && (blk_idx == BLK_W'(b))) begin
                    blk_lock[b] <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_lock <= 1'b0;
        end else if (set_master) begin
            master_lock <= 1'b1;
        end
    end
endmodule

// File: rtl/fcs_timer.sv
`timescale 1ns/1ps
module fcs_timer #(
    parameter int BUSY_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(BUSY_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int BLK_W    = 2,
    parameter int BUSY_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              vpen_ok,
    input  logic              hv_rst,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);
    import fcs_pkg::*;

    localparam int NBLK = 1 << BLK_W;

    fcs_state_e        state_q, state_d;
    logic              rd_status_q;
    logic [7:0]        err_q;

    logic              pgm_en, set_blk, set_master, tmr_start, tmr_done;
    logic              go_status, go_array, err_clr;
    logic [7:0]        err_set;
    logic [NBLK-1:0]   blk_lock;
    logic              master_lock;
    logic [DATA_W-1:0] arr_rd;
    logic [7:0]        status_byte;
    logic [DATA_W-1:0] status_ext;

    wire  [BLK_W-1:0]  blk_idx = addr[ADDR_W-1 -: BLK_W];
    wire  [7:0]        cmd     = wdata[7:0];

    fcs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_en   (pgm_en),
        .pgm_addr (addr),
        .pgm_data (wdata),
        .rd_addr  (addr),
        .rd_data  (arr_rd)
    );

    fcs_locks #(.BLK_W(BLK_W)) u_locks (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_blk     (set_blk),
        .blk_idx     (blk_idx),
        .set_master  (set_master),
        .blk_lock    (blk_lock),
        .master_lock (master_lock)
    );

    fcs_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Command decode, protection gating and next state
    always_comb begin
        state_d    = state_q;
        pgm_en     = 1'b0;
        set_blk    = 1'b0;
        set_master = 1'b0;
        tmr_start  = 1'b0;
        go_status  = 1'b0;
        go_array   = 1'b0;
        err_clr    = 1'b0;
        err_set    = 8'h00;
        unique case (state_q)
            ST_IDLE: begin
                if (we) begin
                    case (cmd)
                        CMD_PGM, CMD_PGM_ALT: begin
                            state_d   = ST_PGM_DATA;
                            go_status = 1'b1;
                        end
                        CMD_LOCK_SETUP: begin
                            state_d   = ST_LOCK_CONF;
                            go_status = 1'b1;
                        end
                        CMD_RD_STATUS:  go_status = 1'b1;
                        CMD_RD_ARRAY:   go_array  = 1'b1;
                        CMD_CLR_STATUS: err_clr   = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_PGM_DATA: begin
                if (we) begin
                    state_d   = ST_BUSY;
                    tmr_start = 1'b1;
                    if (!vpen_ok) begin
                        err_set[SR_WERR] = 1'b1;
                        err_set[SR_VLOW] = 1'b1;
                    end else if (blk_lock[blk_idx] && !hv_rst) begin
                        err_set[SR_WERR] = 1'b1;
                        err_set[SR_PROT] = 1'b1;
                    end else begin
                        pgm_en = 1'b1;
                    end
                end
            end
            ST_LOCK_CONF: begin
                if (we) begin
                    if ((cmd == CMD_CONF_BLOCK) || (cmd == CMD_CONF_MSTR)) begin
                        state_d   = ST_BUSY;
                        tmr_start = 1'b1;
                        if (!vpen_ok) begin
                            err_set[SR_WERR] = 1'b1;
                            err_set[SR_VLOW] = 1'b1;
                        end else if (cmd == CMD_CONF_MSTR) begin
                            if (hv_rst) begin
                                set_master = 1'b1;
                            end else begin
                                err_set[SR_WERR] = 1'b1;
                                err_set[SR_PROT] = 1'b1;
                            end
                        end else if (master_lock && !hv_rst) begin
                            err_set[SR_WERR] = 1'b1;
                            err_set[SR_PROT] = 1'b1;
                        end else begin
                            set_blk = 1'b1;
                        end
                    end else begin
                        state_d          = ST_IDLE;
                        err_set[SR_SEQ]  = 1'b1;
                        err_set[SR_WERR] = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Status flags and read mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q       <= 8'h00;
            rd_status_q <= 1'b0;
        end else begin
            if (err_clr) begin
                err_q <= 8'h00;
            end else begin
                err_q <= (err_q | err_set) & ERR_MASK;
            end
            if (go_status) begin
                rd_status_q <= 1'b1;
            end else if (go_array) begin
                rd_status_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        ready                 = (state_q != ST_BUSY);
        status_byte           = err_q & ERR_MASK;
        status_byte[SR_READY] = ready;
        status_ext            = '0;
        status_ext[7:0]       = status_byte;
        rdata                 = rd_status_q ? status_ext : arr_rd;
    end
endmodule

// File: rtl/fcs_checker.sv
`timescale 1ns/1ps
module fcs_checker #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int BLK_W    = 2,
    parameter int BUSY_CYC = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   we,
    input logic [ADDR_W-1:0]      addr,
    input logic [DATA_W-1:0]      wdata,
    input logic                   vpen_ok,
    input logic                   hv_rst,
    input logic [DATA_W-1:0]      rdata,
    input logic                   ready,
    input fcs_pkg::fcs_state_e    state,
    input logic                   rd_status,
    input logic [7:0]             err,
    input logic [(1<<BLK_W)-1:0]  blk_lock,
    input logic                   master_lock
);
    import fcs_pkg::*;

    wire [BLK_W-1:0] blk = addr[ADDR_W-1 -: BLK_W];
    logic [15:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (state == ST_BUSY) begin
            busy_run <= busy_run + 1'b1;
        end else begin
            busy_run <= '0;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            p_busy_len_r9: assert (busy_run <= 16'(BUSY_CYC))
                else $error("busy period longer than BUSY_CYC");
        end
    end

    p_sr7_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |-> (rdata[7] == ready));

    p_vlow_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM_DATA && we && !vpen_ok) |=> (err[4] && err[3]));

    p_prot_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM_DATA && we && vpen_ok && blk_lock[blk] && !hv_rst)
        |=> (err[4] && err[1]));

    p_busy_locks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && we) |=> ($stable(blk_lock) && $stable(master_lock)));

    p_master_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        master_lock |=> master_lock);

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && we && wdata[7:0] == 8'h50) |=> (err == 8'h00));
endmodule

bind flash_cmd_seq fcs_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .BUSY_CYC(BUSY_CYC)
) u_fcs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (we),
    .addr        (addr),
    .wdata       (wdata),
    .vpen_ok     (vpen_ok),
    .hv_rst      (hv_rst),
    .rdata       (rdata),
    .ready       (ready),
    .state       (state_q),
    .rd_status   (rd_status_q),
    .err         (err_q),
    .blk_lock    (blk_lock),
    .master_lock (master_lock)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int BLK_W    = 2;
    localparam int BUSY_CYC = 8;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int NBLK     = 1 << BLK_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              vpen_ok = 1'b1;
    logic              hv_rst = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              ready;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    logic [7:0] m_mem [DEPTH];
    bit         m_lock [NBLK];
    bit         m_master;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
                    .BUSY_CYC(BUSY_CYC)) i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .vpen_ok(vpen_ok), .hv_rst(hv_rst), .rdata(rdata), .ready(ready)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] exp_prog_sr(bit vp, bit hv, bit locked);
        if (!vp) return 8'h98;
        if (locked && !hv) return 8'h92;
        return 8'h80;
    endfunction

    function automatic int blk_of(logic [7:0] a);
        return int'(a[ADDR_W-1 -: BLK_W]);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic prog(logic [7:0] cmd, logic [7:0] a, logic [7:0] d,
                        output logic [7:0] sr, output int busy);
        wr(8'h00, cmd);
        wr(a, d);
        wait_ready(busy);
        rd(a, sr);
        if (vpen_ok && !(m_lock[blk_of(a)] && !hv_rst))
            m_mem[a] = m_mem[a] & d;
    endtask

    task automatic lock_op(logic [7:0] a, logic [7:0] conf,
                           output logic [7:0] sr, output int busy);
        wr(a, 8'h60);
        wr(a, conf);
        wait_ready(busy);
        rd(a, sr);
    endtask

    task automatic read_array(logic [7:0] a, output logic [7:0] v);
        wr(8'h00, 8'hFF);
        rd(a, v);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v, sr;
        int busy;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        for (int b = 0; b < NBLK; b++) m_lock[b] = 0;
        m_master = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h00, v);  chk("R1 array erased", v, 8'hFF);
        rd(8'hFF, v);  chk("R1 array erased top", v, 8'hFF);
        chk("R1 ready", ready, 1);
        wr(8'h00, 8'h70); rd(8'h00, v); chk("R1 status", v, 8'h80);

        // R2, R9: program and busy timing
        wr(8'h00, 8'h40);
        wr(8'h05, 8'hA5);
        rd(8'h05, v); chk("R9 sr7 low while busy", v[7], 0);
        wait_ready(busy);
        chk("R9 busy length", busy, BUSY_CYC - 1 + 1);
        rd(8'h05, sr); chk("R2 status ok", sr, 8'h80);
        m_mem[8'h05] = 8'hA5;
        read_array(8'h05, v); chk("R2 stored", v, 8'hA5);
        prog(8'h40, 8'h05, 8'h5A, sr, busy);
        chk("R2 one over zero no error", sr, 8'h80);
        read_array(8'h05, v); chk("R2 and result", v, 8'h00);

        // R12: alias and mode commands
        prog(8'h10, 8'h06, 8'h3C, sr, busy);
        chk("R12 alias status", sr, 8'h80);
        read_array(8'h06, v); chk("R12 alias stored", v, 8'h3C);
        wr(8'h06, 8'h70); rd(8'h06, v); chk("R12 status mode", v, 8'h80);
        wr(8'h06, 8'hFF); rd(8'h06, v); chk("R12 array mode", v, 8'h3C);
        wr(8'h06, 8'h22); rd(8'h06, v); chk("R12 unknown ignored", v, 8'h3C);

        // R3: supply lockout
        vpen_ok = 1'b0;
        prog(8'h40, 8'h07, 8'h00, sr, busy);
        chk("R3 vlow status", sr, 8'h98);
        chk("R9 busy on reject", busy, BUSY_CYC);
        vpen_ok = 1'b1;
        // R11: sticky then clear
        wr(8'h00, 8'h70); rd(8'h07, v); chk("R11 sticky", v, 8'h98);
        wr(8'h00, 8'h50); rd(8'h07, v); chk("R11 cleared", v, 8'h80);
        read_array(8'h07, v); chk("R3 word unchanged", v, 8'hFF);
        vpen_ok = 1'b0;
        lock_op(8'h40, 8'h01, sr, busy);
        chk("R3 vlow lock status", sr, 8'h98);
        vpen_ok = 1'b1;
        wr(8'h00, 8'h50);
        prog(8'h40, 8'h48, 8'h0F, sr, busy);
        chk("R3 lock not set", sr, 8'h80);

        // R5: block lock
        lock_op(8'h40, 8'h01, sr, busy);
        chk("R5 lock status", sr, 8'h80);
        m_lock[1] = 1;
        // R4: locked program
        prog(8'h40, 8'h45, 8'h00, sr, busy);
        chk("R4 locked status", sr, 8'h92);
        wr(8'h00, 8'h50);
        read_array(8'h45, v); chk("R4 word unchanged", v, 8'hFF);
        prog(8'h40, 8'h85, 8'h11, sr, busy);
        chk("R5 other block writable", sr, 8'h80);
        hv_rst = 1'b1;
        prog(8'h40, 8'h46, 8'h00, sr, busy);
        chk("R4 hv bypass status", sr, 8'h80);
        hv_rst = 1'b0;
        read_array(8'h46, v); chk("R4 hv bypass stored", v, 8'h00);

        // R8: invalid confirm
        lock_op(8'h80, 8'h33, sr, busy);
        chk("R8 bad confirm status", sr, 8'hB0);
        chk("R8 no busy", busy, 0);
        wr(8'h00, 8'h50);
        prog(8'h40, 8'h86, 8'h00, sr, busy);
        chk("R8 nothing locked", sr, 8'h80);

        // R6: master lock needs hv
        lock_op(8'h12, 8'hF1, sr, busy);
        chk("R6 master without hv", sr, 8'h92);
        wr(8'h00, 8'h50);
        lock_op(8'h80, 8'h01, sr, busy);
        chk("R6 master still clear", sr, 8'h80);
        m_lock[2] = 1;
        hv_rst = 1'b1;
        lock_op(8'h33, 8'hF1, sr, busy);
        chk("R6 master with hv", sr, 8'h80);
        hv_rst = 1'b0;
        m_master = 1;

        // R7: block lock under master
        lock_op(8'hC0, 8'h01, sr, busy);
        chk("R7 block lock refused", sr, 8'h92);
        wr(8'h00, 8'h50);
        prog(8'h40, 8'hC0, 8'h00, sr, busy);
        chk("R7 block3 still open", sr, 8'h80);
        hv_rst = 1'b1;
        lock_op(8'hC0, 8'h01, sr, busy);
        chk("R7 block lock with hv", sr, 8'h80);
        hv_rst = 1'b0;
        m_lock[3] = 1;
        prog(8'h40, 8'hC1, 8'h00, sr, busy);
        chk("R7 block3 now locked", sr, 8'h92);
        wr(8'h00, 8'h50);

        // R10: writes during busy ignored
        wr(8'h00, 8'h40);
        wr(8'h10, 8'hF0);
        m_mem[8'h10] = 8'hF0;
        wr(8'h00, 8'h40);
        wr(8'h10, 8'hFF);
        wait_ready(busy);
        wr(8'h10, 8'h00);
        rd(8'h10, v); chk("R10 mode kept", v, 8'h80);
        read_array(8'h10, v); chk("R10 word unchanged", v, 8'hF0);

        // Random programs against model (R2, R3, R4)
        for (int it = 0; it < 120; it++) begin
            logic [7:0] a, d, e;
            bit vp, hv;
            a = 8'($urandom);
            d = 8'($urandom);
            vp = ($urandom % 5) != 0;
            hv = ($urandom % 3) == 0;
            e = exp_prog_sr(vp, hv, m_lock[blk_of(a)]);
            wr(8'h00, 8'h50);
            vpen_ok = vp; hv_rst = hv;
            prog(8'h40, a, d, sr, busy);
            chk("R4 random status", sr, e);
            vpen_ok = 1'b1; hv_rst = 1'b0;
            read_array(a, v);
            chk("R2 random word", v, m_mem[a]);
        end

        finish_run();
    end
endmodule